// File: doc/BRIEF.md
# Reader Byte FIFO with Watermark Status

A twelve-entry byte FIFO placed between the host register side and the transmit/receive framing engine of a contactless card reader. Its direction input picks who writes and who reads. In transmit, the host loads bytes and the framer drains them. In receive, the framer loads bytes and the host drains them. Either way the block keeps one byte queue and one read-data register.

A status byte reports the fill state. The unread count is given as N−1, and a separate empty output tells a single byte apart from none. A direction-dependent watermark flag marks a nearly drained transmit queue or a nearly full receive queue. A sticky overflow flag records a write that arrived while the queue was full. Beside the queue, the block holds a 12-bit transmit byte length that the host writes in two parts. That length clears itself at transmit end-of-frame, and also whenever the enable input is low.

Top module: `rdr_fifo`

## Requirements
- R1: `status[7]` always reads 0. `status[6]` is the high flag, `status[5]` the low flag, `status[4]` the overflow flag and `status[3:0]` the count field.
- R2: With N bytes held (1 ≤ N ≤ 12), `status[3:0]` equals N−1 and `empty` is 0. With N = 0, `status[3:0]` is 0 and `empty` is 1.
- R3: The high flag is 1 exactly when `dir_tx`=0 and N ≥ 9. The low flag is 1 exactly when `dir_tx`=1 and N ≤ 3.
- R4: A write while N = 12 is discarded and leaves the queue contents and count unchanged. It sets the overflow flag, which stays set until `clr`. A read in the same cycle still proceeds.
- R5: Bytes leave in the order they were written. A byte read in one cycle appears on `rd_data` after the next clock edge. A read while empty leaves `rd_data` and N unchanged.
- R6: With `dir_tx`=1, the host writes and the framer reads; `frm_wr` and `host_rd` have no effect. With `dir_tx`=0, the framer writes and the host reads; `host_wr` and `frm_rd` have no effect.
- R7: `clr` empties the queue and clears the overflow flag in one cycle, overriding any write or read in that cycle. It leaves `tx_len` and `rd_data` unchanged.
- R8: `len_wr_hi` loads `len_wdata[7:0]` into `tx_len[11:4]`, and `len_wr_lo` loads `len_wdata[3:0]` into `tx_len[3:0]`. `tx_len` becomes 0 after reset, in any cycle with `en`=0, and in any cycle with `tx_eof`=1. Clearing takes priority over loading.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| en | input | 1 | Block enable; low clears the transmit length |
| dir_tx | input | 1 | 1 = transmit direction, 0 = receive direction |
| clr | input | 1 | FIFO reset command |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| frm_wr | input | 1 | Framer write strobe |
| frm_wdata | input | 8 | Framer write data |
| frm_rd | input | 1 | Framer read strobe |
| rd_data | output | 8 | Last byte read from the queue |
| empty | output | 1 | Queue holds no bytes |
| status | output | 8 | Flags and N−1 count |
| len_wr_hi | input | 1 | Load upper eight length bits |
| len_wr_lo | input | 1 | Load lower four length bits |
| len_wdata | input | 8 | Length write data |
| tx_eof | input | 1 | Transmit end-of-frame pulse |
| tx_len | output | 12 | Transmit byte length |

## Verification
Every state register reaches the ports directly. The count, flags and empty output are combinational from the fill count, so a wrong count shows in `status` in the same cycle as the faulty update. A pointer that slips, or wraps at the wrong entry, shows as a wrong byte on `rd_data` one cycle after the read of the affected entry. That can be as many as twelve reads after the faulty write, so the stimulus fills and drains the queue repeatedly. A lost overflow or length clear shows on the next edge, because both are checked every cycle against a model of the queue.

// File: rtl/rdr_fifo.sv
module rdr_fifo #(
  parameter int DEPTH   = 12,
  parameter int HI_MARK = 9,
  parameter int LO_MARK = 3,
  parameter int LEN_W   = 12,
  parameter int DW      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir_tx,
  input  logic             clr,
  input  logic             host_wr,
  input  logic [DW-1:0]    host_wdata,
  input  logic             host_rd,
  input  logic             frm_wr,
  input  logic [DW-1:0]    frm_wdata,
  input  logic             frm_rd,
  output logic [DW-1:0]    rd_data,
  output logic             empty,
  output logic [7:0]       status,
  input  logic             len_wr_hi,
  input  logic             len_wr_lo,
  input  logic [DW-1:0]    len_wdata,
  input  logic             tx_eof,
  output logic [LEN_W-1:0] tx_len
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int HW = LEN_W - 4;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_m1;
  logic          ovf, full;
  logic          wr, rd, wr_ok, rd_ok;
  logic [DW-1:0] wdata;

  assign wr    = dir_tx ? host_wr : frm_wr;
  assign rd    = dir_tx ? frm_rd  : host_rd;
  assign wdata = dir_tx ? host_wdata : frm_wdata;
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
  assign wr_ok = wr && !full;
  assign rd_ok = rd && !empty;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
      ovf  <= 1'b0;
    end else begin
      if (wr_ok) begin
        mem[wptr] <= wdata;
        wptr      <= bump(wptr);
      end
      if (rd_ok) rptr <= bump(rptr);
      if (wr && full) ovf <= 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              rd_data <= '0;
    else if (rd_ok && !clr)  rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en || tx_eof) tx_len <= '0;
    else begin
      if (len_wr_hi) tx_len[LEN_W-1:4] <= len_wdata[HW-1:0];
      if (len_wr_lo) tx_len[3:0]       <= len_wdata[3:0];
    end
  end

  assign cnt_m1 = empty ? '0 : cnt - CW'(1);
  assign status = {1'b0,
                   !dir_tx && (cnt >= CW'(HI_MARK)),
                   dir_tx && (cnt <= CW'(LO_MARK)),
                   ovf,
                   cnt_m1[3:0]};
endmodule

module rdr_fifo_chk #(
  parameter int DEPTH = 12
) (
  input logic        clk,
  input logic        rst_n,
  input logic        en,
  input logic        dir_tx,
  input logic        clr,
  input logic        host_wr,
  input logic        host_rd,
  input logic        frm_wr,
  input logic        frm_rd,
  input logic [7:0]  rd_data,
  input logic        empty,
  input logic [7:0]  status,
  input logic        tx_eof,
  input logic [11:0] tx_len
);
  logic wr_c, rd_c, full_c;
  assign wr_c   = dir_tx ? host_wr : frm_wr;
  assign rd_c   = dir_tx ? frm_rd : host_rd;
  assign full_c = !empty && (status[3:0] == 4'(DEPTH - 1));

  a_r2_empty_count: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> status[3:0] == 4'd0);
  a_r3_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[6] && status[5]));
  a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_c && full_c && !clr) |=> status[4]);
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (status[4] && !clr) |=> status[4]);
  a_r5_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && empty && !clr) |=> $stable(rd_data));
  a_r7_clr_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !status[4]));
  a_r8_len_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || tx_eof) |=> tx_len == 12'd0);
endmodule

bind rdr_fifo rdr_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .dir_tx(dir_tx), .clr(clr),
  .host_wr(host_wr), .host_rd(host_rd), .frm_wr(frm_wr), .frm_rd(frm_rd),
  .rd_data(rd_data), .empty(empty), .status(status), .tx_eof(tx_eof),
  .tx_len(tx_len)
);

// File: tb/rdr_fifo_test.sv
module rdr_fifo_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b1, dir_tx = 1'b1, clr = 1'b0;
  logic host_wr = 0, host_rd = 0, frm_wr = 0, frm_rd = 0;
  logic [7:0] host_wdata = 0, frm_wdata = 0, len_wdata = 0;
  logic len_wr_hi = 0, len_wr_lo = 0, tx_eof = 0;
  logic [7:0] rd_data, status;
  logic empty;
  logic [11:0] tx_len;

  int checks = 0, failures = 0;
  logic [7:0] q[$];
  bit m_ovf;
  logic [7:0] m_last;
  logic [11:0] m_len;

  always #10 clk = ~clk;

  rdr_fifo uut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(int n, bit ovf, bit dtx);
    logic [7:0] s;
    s[7] = 1'b0;
    s[6] = !dtx && n >= 9;
    s[5] = dtx && n <= 3;
    s[4] = ovf;
    s[3:0] = (n == 0) ? 4'd0 : 4'(n - 1);
    return s;
  endfunction

  task automatic compare_all();
    logic [7:0] e;
    e = exp_status(q.size(), m_ovf, dir_tx);
    check(status[7] == 1'b0, "R1 reserved bit", status[7], 0);
    check(status[3:0] == e[3:0], "R2 count field", status[3:0], e[3:0]);
    check(empty == (q.size() == 0), "R2 empty", empty, q.size() == 0);
    check(status[6:5] == e[6:5], "R3 watermark flags", status[6:5], e[6:5]);
    check(status[4] == e[4], "R4 overflow flag", status[4], e[4]);
    check(rd_data == m_last, "R5 read data", rd_data, m_last);
    check(tx_len == m_len, "R8 tx length", tx_len, m_len);
  endtask

  task automatic cyc(input bit c, input bit d, input bit hw, input bit fw,
                     input bit hr, input bit fr, input logic [7:0] hd,
                     input logic [7:0] fd, input bit lh, input bit ll,
                     input logic [7:0] ld, input bit e, input bit eof);
    bit wr, rd;
    int n;
    clr = c; dir_tx = d; host_wr = hw; frm_wr = fw; host_rd = hr; frm_rd = fr;
    host_wdata = hd; frm_wdata = fd; len_wr_hi = lh; len_wr_lo = ll;
    len_wdata = ld; en = e; tx_eof = eof;
    wr = d ? hw : fw;
    rd = d ? fr : hr;
    n = q.size();
    if (c) begin
      q.delete();
      m_ovf = 0;
    end else begin
      if (rd && n > 0) m_last = q.pop_front();
      if (wr) begin
        if (n < 12) q.push_back(d ? hd : fd);
        else m_ovf = 1;
      end
    end
    if (!e || eof) m_len = '0;
    else begin
      if (lh) m_len[11:4] = ld;
      if (ll) m_len[3:0] = ld[3:0];
    end
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle(input bit d);
    cyc(0, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    q.delete(); m_ovf = 0; m_last = 0; m_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(empty == 1'b1, "R2 reset empty", empty, 1);
    check(status == 8'h20, "R1 reset status", status, 8'h20);
    check(rd_data == 8'h00, "R5 reset rd_data", rd_data, 0);
    check(tx_len == 12'h000, "R8 reset length", tx_len, 0);

    // R6: wrong-side strobes ignored in transmit
    cyc(0, 1, 0, 1, 1, 0, 8'h11, 8'h22, 0, 0, 0, 1, 0);
    check(empty == 1'b1, "R6 framer write ignored in transmit", empty, 1);

    // R3/R4: receive fill to 12 then overflow
    for (int i = 0; i < 12; i++) cyc(0, 0, 0, 1, 0, 0, 0, 8'(8'hA0 + i), 0, 0, 0, 1, 0);
    check(status == 8'h4B, "R3 high flag at twelve", status, 8'h4B);
    cyc(0, 0, 1, 0, 0, 0, 8'h55, 0, 0, 0, 0, 1, 0);
    check(status[4] == 1'b0, "R6 host write ignored in receive", status[4], 0);
    cyc(0, 0, 0, 1, 0, 0, 0, 8'hEE, 0, 0, 0, 1, 0);
    check(status == 8'h5B, "R4 overflow on full write", status, 8'h5B);
    for (int i = 0; i < 12; i++) begin
      cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0);
      check(rd_data == 8'(8'hA0 + i), "R5 fifo order", rd_data, 8'hA0 + i);
    end
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 1, 0);
    check(rd_data == 8'hAB && empty, "R5 empty read holds data", rd_data, 8'hAB);
    check(status[4] == 1'b1, "R4 overflow sticky", status[4], 1);

    // R7: clear with length held
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, 1, 8'h9C, 1, 0);
    cyc(0, 1, 1, 0, 0, 0, 8'h31, 0, 0, 0, 0, 1, 0);
    cyc(1, 1, 1, 0, 0, 0, 8'h32, 0, 0, 0, 0, 1, 0);
    check(empty && !status[4], "R7 clear empties and drops overflow", status, 8'h20);
    check(tx_len == 12'h9CC, "R7 clear keeps length", tx_len, 12'h9CC);

    // R3: low flag boundary in transmit
    for (int i = 0; i < 3; i++) cyc(0, 1, 1, 0, 0, 0, 8'(i), 0, 0, 0, 0, 1, 0);
    check(status == 8'h22, "R3 low flag at three", status, 8'h22);
    cyc(0, 1, 1, 0, 0, 0, 8'h03, 0, 0, 0, 0, 1, 0);
    check(status == 8'h03, "R3 low flag off at four", status, 8'h03);

    // R8: end-of-frame clear wins over load
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 8'h7F, 1, 1);
    check(tx_len == 12'h000, "R8 eof clears length", tx_len, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 8'h12, 1, 0);
    cyc(0, 1, 0, 0, 0, 0, 0, 0, 0, 1, 8'h0F, 0, 0);
    check(tx_len == 12'h000, "R8 enable low clears length", tx_len, 0);
    idle(1);

    for (int k = 0; k < 4000; k++) begin
      bit d = ($urandom % 64) < 32 ? 1'b1 : ($urandom % 2 == 1);
      cyc(($urandom % 60) == 0, d, ($urandom % 3) != 0, ($urandom % 3) != 0,
          ($urandom % 2) == 1, ($urandom % 2) == 1, 8'($urandom), 8'($urandom),
          ($urandom % 8) == 0, ($urandom % 8) == 0, 8'($urandom),
          ($urandom % 50) != 0, ($urandom % 40) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule